// File: doc/BRIEF.md
# Station Address Table with Aging

This block keeps a table of station addresses for every port of a small bridge. The bridge hands it a source address once a frame has arrived whole and good. The block stores that address in the table of the port the frame came in on. When the bridge has captured the destination address of a frame, it asks the table about it. If the destination is a station already known on the receiving port, the frame is local and the bridge drops it. If not, the frame goes to the other port.

Storage is direct-mapped. The index of an address is taken from the low bits of a CRC-32 of that address. A new address that maps to an occupied slot replaces the old one. Each slot holds a valid flag and an age flag. A counter of aging ticks starts a background sweep once every half aging period. The sweep visits one slot per cycle. It clears the age flag of a live slot, or it invalidates the slot if that flag was already clear. A station that stays silent for between one half period and one full period of ticks is therefore forgotten.

A lookup and a learn can arrive in the same cycle. The lookup always goes first. The learn waits in a one-deep holding register until a cycle with no lookup. The sweep only moves forward in cycles with no table write.

Top module: `sta_table`

## Requirements
- R1: After reset every slot of every port is invalid. A lookup of any address returns look_hit=0 and look_fwd=1.
- R2: A lookup presented in a cycle gives look_done=1 in the next cycle, with exactly one of look_hit and look_fwd set. In every other cycle look_done, look_hit and look_fwd are 0.
- R3: A learned unicast address (bit 40 of the 48-bit value equal to 0) is entered in the table of learn_port. A later lookup of that address on the same port returns look_hit=1 and look_fwd=0.
- R4: The tables of the ports are separate. An address learned on one port misses on a lookup from another port and gives look_fwd=1.
- R5: A learn whose address has bit 40 set (a group address) is ignored, and a later lookup of that address misses.
- R6: The slot index is the low log2(TABLE_ENTRIES/NUM_PORTS) bits of a CRC-32 of the address. The CRC uses polynomial 0x04C11DB7 and an all-ones start value, takes address bit 47 first and bit 0 last, and is not reflected or inverted. Learning a second address with the same index on the same port replaces the first: the first then misses and the second hits.
- R7: When a learn and a lookup come in the same cycle, the lookup result reflects the table before that learn. The learn is written in the next cycle with no lookup. If a second learn arrives while one is still held, only the newer one is kept.
- R8: A sweep starts on every (AGE_TICKS/2)-th pulse of age_tick. An entry that has seen one sweep since it was last learned still hits. An entry that has seen two sweeps is removed and misses.
- R9: Learning an address again sets its age flag, so after a further sweep the entry still hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| learn_req | input | 1 | Learn strobe for a good, fully received frame |
| learn_port | input | PORT_W | Port the frame arrived on |
| learn_mac | input | 48 | Source address to learn |
| look_req | input | 1 | Lookup strobe once the destination is captured |
| look_port | input | PORT_W | Port the frame arrived on |
| look_mac | input | 48 | Destination address to look up |
| age_tick | input | 1 | Aging time base pulse |
| look_done | output | 1 | Lookup result valid |
| look_hit | output | 1 | Destination is known on the receiving port (local, drop) |
| look_fwd | output | 1 | Destination is not local; forward to the other port |

## Verification
Directed cases pin down behaviour that random traffic is unlikely to reach:
- a learn on one port followed by lookups from both ports, which separates the per-port tables;
- a group-address learn;
- a pair of addresses picked by the bench to share a slot, which shows replacement on collision;
- a learn and a lookup in the same cycle, and two held learns in a row, which show the priority rule and that the newest held learn wins;
- tick sequences that put one or two sweeps after a learn, with and without a refresh in between, which separate the age flag from the valid flag.

Seeded random mixes of learns, lookups and ticks over a small address pool then compare every lookup against a table model kept in the bench.

// File: rtl/sta_pkg.sv
package sta_pkg;

   localparam int MAC_W     = 48;
   localparam int GROUP_BIT = 40;
   localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

   typedef enum logic {SWP_IDLE, SWP_RUN} sweep_state_e;

   // CRC-32, address bit 47 first, all-ones start, no reflection or inversion
   function automatic logic [31:0] mac_crc32(input logic [MAC_W-1:0] mac);
      logic [31:0] acc;
      logic        fb;
      acc = 32'hFFFF_FFFF;
      for (int b = MAC_W - 1; b >= 0; b--) begin
         fb  = acc[31] ^ mac[b];
         acc = {acc[30:0], 1'b0};
         if (fb) acc = acc ^ CRC_POLY;
      end
      return acc;
   endfunction

endpackage

// File: rtl/sta_hash.sv
module sta_hash
   import sta_pkg::*;
#(
   parameter int IDX_W = 10
) (
   input  logic [MAC_W-1:0] mac,
   output logic [IDX_W-1:0] idx
);

   generate
      if (IDX_W < 1 || IDX_W > 32) begin : g_bad_width
         $error("sta_hash: IDX_W must be within 1..32");
      end
   endgenerate

   assign idx = IDX_W'(mac_crc32(mac));

endmodule

// File: rtl/sta_learn_arb.sv
module sta_learn_arb
   import sta_pkg::*;
#(
   parameter int PORT_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              learn_req,
   input  logic [PORT_W-1:0] learn_port,
   input  logic [MAC_W-1:0]  learn_mac,
   input  logic              look_req,
   output logic              wr_en,
   output logic [PORT_W-1:0] wr_port,
   output logic [MAC_W-1:0]  wr_mac
);

   logic              hold_vld;
   logic [PORT_W-1:0] hold_port;
   logic [MAC_W-1:0]  hold_mac;
   logic              accept;

   // group source addresses never enter the table
   assign accept  = learn_req && !learn_mac[GROUP_BIT];

   assign wr_en   = !look_req && (hold_vld || accept);
   assign wr_port = hold_vld ? hold_port : learn_port;
   assign wr_mac  = hold_vld ? hold_mac  : learn_mac;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_vld  <= 1'b0;
         hold_port <= '0;
         hold_mac  <= '0;
      end else if (look_req) begin
         if (accept) begin
            hold_vld  <= 1'b1;
            hold_port <= learn_port;
            hold_mac  <= learn_mac;
         end
      end else if (hold_vld) begin
         if (accept) begin
            hold_port <= learn_port;
            hold_mac  <= learn_mac;
         end else begin
            hold_vld  <= 1'b0;
         end
      end
   end

   // R7: a held learn with no competition drains in one cycle
   p_hold_drains_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hold_vld && !look_req && !learn_req |=> !hold_vld);

   // R5: nothing with the group bit set ever reaches the table
   p_group_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !wr_mac[GROUP_BIT]);

endmodule

// File: rtl/sta_age_ctrl.sv
module sta_age_ctrl
   import sta_pkg::*;
#(
   parameter int AGE_TICKS = 300,
   parameter int IDX_W     = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             age_tick,
   input  logic             step_ok,
   output logic             sw_en,
   output logic [IDX_W-1:0] sw_idx
);

   localparam int HALF   = AGE_TICKS / 2;
   localparam int TICK_W = $clog2(HALF);

   generate
      if (AGE_TICKS < 4 || (AGE_TICKS % 2) != 0) begin : g_bad_age
         $error("sta_age_ctrl: AGE_TICKS must be even and at least 4");
      end
   endgenerate

   sweep_state_e      state;
   logic [TICK_W-1:0] tick_cnt;
   logic              start;

   assign start = age_tick && (tick_cnt == TICK_W'(HALF - 1));
   assign sw_en = (state == SWP_RUN) && step_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_cnt <= '0;
      end else if (age_tick) begin
         tick_cnt <= start ? '0 : tick_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SWP_IDLE;
         sw_idx <= '0;
      end else if (start) begin
         state  <= SWP_RUN;
         sw_idx <= '0;
      end else if (sw_en) begin
         sw_idx <= sw_idx + 1'b1;
         if (&sw_idx) state <= SWP_IDLE;
      end
   end

   // R8: the half-period tick launches a sweep from slot zero
   p_sweep_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (state == SWP_RUN) && (sw_idx == '0));

   // R8: the tick counter stays below the half period
   p_tick_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      32'(tick_cnt) < HALF);

endmodule

// File: rtl/sta_bank.sv
module sta_bank
   import sta_pkg::*;
#(
   parameter int IDX_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [MAC_W-1:0] wr_mac,
   input  logic             sw_en,
   input  logic [IDX_W-1:0] sw_idx,
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [MAC_W-1:0] rd_mac
);

   localparam int DEPTH = 1 << IDX_W;

   logic             ent_vld [DEPTH];
   logic             ent_age [DEPTH];
   logic [MAC_W-1:0] ent_mac [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            ent_vld[i] <= 1'b0;
            ent_age[i] <= 1'b0;
         end
      end else begin
         if (sw_en && ent_vld[sw_idx]) begin
            if (ent_age[sw_idx]) ent_age[sw_idx] <= 1'b0;
            else                 ent_vld[sw_idx] <= 1'b0;
         end
         if (wr_en) begin
            ent_vld[wr_idx] <= 1'b1;
            ent_age[wr_idx] <= 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) ent_mac[wr_idx] <= wr_mac;
   end

   assign rd_valid = ent_vld[rd_idx];
   assign rd_mac   = ent_mac[rd_idx];

   // R3 and R9: a write leaves its slot live and freshly aged
   p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ent_vld[$past(wr_idx)] && ent_age[$past(wr_idx)]);

endmodule

// File: rtl/sta_table.sv
module sta_table
   import sta_pkg::*;
#(
   parameter int TABLE_ENTRIES = 2048,
   parameter int NUM_PORTS     = 2,
   parameter int AGE_TICKS     = 300,
   localparam int PORT_W       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              learn_req,
   input  logic [PORT_W-1:0] learn_port,
   input  logic [MAC_W-1:0]  learn_mac,
   input  logic              look_req,
   input  logic [PORT_W-1:0] look_port,
   input  logic [MAC_W-1:0]  look_mac,
   input  logic              age_tick,
   output logic              look_done,
   output logic              look_hit,
   output logic              look_fwd
);

   localparam int DEPTH = TABLE_ENTRIES / NUM_PORTS;
   localparam int IDX_W = $clog2(DEPTH);

   generate
      if (NUM_PORTS < 2 || (NUM_PORTS & (NUM_PORTS - 1)) != 0) begin : g_bad_ports
         $error("sta_table: NUM_PORTS must be a power of two, at least 2");
      end
      if (DEPTH < 2 || (1 << IDX_W) != DEPTH || DEPTH * NUM_PORTS != TABLE_ENTRIES) begin : g_bad_depth
         $error("sta_table: TABLE_ENTRIES / NUM_PORTS must be a power of two");
      end
   endgenerate

   logic              wr_en;
   logic [PORT_W-1:0] wr_port;
   logic [MAC_W-1:0]  wr_mac;
   logic [IDX_W-1:0]  wr_idx;
   logic [IDX_W-1:0]  look_idx;
   logic              sw_en;
   logic [IDX_W-1:0]  sw_idx;
   logic              bank_vld [NUM_PORTS];
   logic [MAC_W-1:0]  bank_mac [NUM_PORTS];
   logic              hit_c;

   sta_learn_arb #(.PORT_W(PORT_W)) arb_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .learn_req  (learn_req),
      .learn_port (learn_port),
      .learn_mac  (learn_mac),
      .look_req   (look_req),
      .wr_en      (wr_en),
      .wr_port    (wr_port),
      .wr_mac     (wr_mac)
   );

   sta_hash #(.IDX_W(IDX_W)) wr_hash_i   (.mac(wr_mac),   .idx(wr_idx));
   sta_hash #(.IDX_W(IDX_W)) look_hash_i (.mac(look_mac), .idx(look_idx));

   sta_age_ctrl #(.AGE_TICKS(AGE_TICKS), .IDX_W(IDX_W)) age_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .age_tick (age_tick),
      .step_ok  (!wr_en),
      .sw_en    (sw_en),
      .sw_idx   (sw_idx)
   );

   generate
      for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bank
         sta_bank #(.IDX_W(IDX_W)) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en && (wr_port == PORT_W'(p))),
            .wr_idx   (wr_idx),
            .wr_mac   (wr_mac),
            .sw_en    (sw_en),
            .sw_idx   (sw_idx),
            .rd_idx   (look_idx),
            .rd_valid (bank_vld[p]),
            .rd_mac   (bank_mac[p])
         );
      end
   endgenerate

   assign hit_c = bank_vld[look_port] && (bank_mac[look_port] == look_mac);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         look_done <= 1'b0;
         look_hit  <= 1'b0;
         look_fwd  <= 1'b0;
      end else begin
         look_done <= look_req;
         look_hit  <= look_req && hit_c;
         look_fwd  <= look_req && !hit_c;
      end
   end

   // R8: the sweep never steps in a cycle that writes the table
   p_sweep_yields_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sw_en |-> !wr_en);

   // R7: a lookup cycle never carries a table write
   p_lookup_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
      look_req |-> !wr_en);

   // R2: a request is answered in the next cycle
   p_answer_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
      look_req |=> look_done && (look_hit != look_fwd));

endmodule

// File: tb/sta_table_tb.sv
module sta_table_tb_top;

   localparam int ENT  = 64;
   localparam int NP   = 2;
   localparam int AT   = 4;
   localparam int DEP  = ENT / NP;
   localparam int IW   = $clog2(DEP);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        learn_req = 1'b0;
   logic [0:0]  learn_port = '0;
   logic [47:0] learn_mac = '0;
   logic        look_req = 1'b0;
   logic [0:0]  look_port = '0;
   logic [47:0] look_mac = '0;
   logic        age_tick = 1'b0;
   logic        look_done, look_hit, look_fwd;

   int n_tests = 0;
   int n_fail  = 0;
   bit ended   = 0;

   always #2 clk = ~clk;

   sta_table #(.TABLE_ENTRIES(ENT), .NUM_PORTS(NP), .AGE_TICKS(AT)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .learn_req(learn_req), .learn_port(learn_port), .learn_mac(learn_mac),
      .look_req(look_req), .look_port(look_port), .look_mac(look_mac),
      .age_tick(age_tick),
      .look_done(look_done), .look_hit(look_hit), .look_fwd(look_fwd)
   );

   // reference table
   bit          m_vld [NP][DEP];
   bit          m_age [NP][DEP];
   logic [47:0] m_mac [NP][DEP];
   int          m_ticks = 0;

   function automatic int bidx(input logic [47:0] a);
      logic [31:0] r = 32'hFFFFFFFF;
      for (int k = 47; k >= 0; k--) begin
         if (r[31] ^ a[k]) r = (r << 1) ^ 32'h04C11DB7;
         else              r = r << 1;
      end
      return int'(r) & (DEP - 1);
   endfunction

   function automatic bit m_hit(input int p, input logic [47:0] a);
      int i = bidx(a);
      return m_vld[p][i] && (m_mac[p][i] == a);
   endfunction

   task automatic m_learn(input int p, input logic [47:0] a);
      int i;
      if (!a[40]) begin
         i = bidx(a);
         m_vld[p][i] = 1; m_age[p][i] = 1; m_mac[p][i] = a;
      end
   endtask

   task automatic m_tick();
      m_ticks++;
      if (m_ticks == AT / 2) begin
         m_ticks = 0;
         for (int p = 0; p < NP; p++)
            for (int i = 0; i < DEP; i++)
               if (m_vld[p][i]) begin
                  if (m_age[p][i]) m_age[p][i] = 0;
                  else             m_vld[p][i] = 0;
               end
      end
   endtask

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic t_learn(input int p, input logic [47:0] a);
      @(negedge clk);
      learn_req = 1; learn_port = 1'(p); learn_mac = a;
      @(negedge clk);
      learn_req = 0;
      m_learn(p, a);
   endtask

   task automatic t_look(input string tag, input int p, input logic [47:0] a);
      bit e;
      @(negedge clk);
      look_req = 1; look_port = 1'(p); look_mac = a;
      e = m_hit(p, a);
      @(negedge clk);
      look_req = 0;
      check({tag, " done"}, 64'(look_done), 64'(1));
      check({tag, " hit"},  64'(look_hit),  64'(e));
      check({tag, " fwd"},  64'(look_fwd),  64'(!e));
   endtask

   task automatic t_tick();
      @(negedge clk);
      age_tick = 1;
      @(negedge clk);
      age_tick = 0;
      m_tick();
      repeat (DEP + 8) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin : main
      logic [47:0] a, b, pool [16];
      void'($urandom(32'h5EED_0502));
      for (int p = 0; p < NP; p++)
         for (int i = 0; i < DEP; i++) begin
            m_vld[p][i] = 0; m_age[p][i] = 0; m_mac[p][i] = '0;
         end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      check("R1 idle done", 64'(look_done), 64'(0));
      t_look("R1 empty p0", 0, 48'h0012_3456_789A);
      t_look("R1 empty p1", 1, 48'h0000_0000_0000);
      // R2 idle after a result
      @(negedge clk);
      check("R2 done drops", 64'({look_done, look_hit, look_fwd}), 64'(0));

      // R3 and R4
      a = 48'h0200_1122_3344;
      t_learn(0, a);
      t_look("R3 learned hit", 0, a);
      check("R3 explicit", 64'(m_hit(0, a)), 64'(1));
      t_look("R4 other port", 1, a);

      // R5 group address
      b = 48'h0100_5E00_0001;
      t_learn(1, b);
      t_look("R5 group ignored", 1, b);
      check("R5 explicit", 64'(m_hit(1, b)), 64'(0));

      // R6 collision on port 1
      a = 48'h0000_AB00_0010;
      b = a;
      for (int k = 1; k < 5000; k++) begin
         b = a + 48'(k * 2 * 48'h100_0000_0000 / 48'h100_0000_0000 * 2);
         b[40] = 1'b0;
         if (b != a && bidx(b) == bidx(a)) break;
      end
      check("R6 collision found", 64'(bidx(b) == bidx(a) && b != a), 64'(1));
      t_learn(1, a);
      t_learn(1, b);
      t_look("R6 old replaced", 1, a);
      t_look("R6 new present", 1, b);

      // R7 same-cycle learn and lookup
      a = 48'h0000_7777_0001;
      @(negedge clk);
      look_req = 1; look_port = 0; look_mac = a;
      learn_req = 1; learn_port = 0; learn_mac = a;
      @(negedge clk);
      look_req = 0; learn_req = 0;
      check("R7 lookup before learn", 64'({look_done, look_hit, look_fwd}), 64'b101);
      m_learn(0, a);
      t_look("R7 held learn written", 0, a);

      // R7 newest held learn wins
      a = 48'h0000_8888_0001;
      b = 48'h0000_8888_0002;
      @(negedge clk);
      look_req = 1; look_port = 1; look_mac = 48'h0000_0000_0F0F;
      learn_req = 1; learn_port = 1; learn_mac = a;
      @(negedge clk);
      learn_mac = b;
      @(negedge clk);
      look_req = 0; learn_req = 0;
      m_learn(1, b);
      if (bidx(a) != bidx(b)) check("R7 older dropped", 64'(m_hit(1, a)), 64'(0));
      t_look("R7 older dropped", 1, a);
      t_look("R7 newer kept", 1, b);

      // R8 aging across sweeps (tick counter is at zero here)
      a = 48'h0000_CAFE_0001;
      t_learn(0, a);
      t_tick();
      t_look("R8 no sweep yet", 0, a);
      t_tick();
      t_look("R8 one sweep hit", 0, a);
      check("R8 one sweep explicit", 64'(m_hit(0, a)), 64'(1));
      t_tick(); t_tick();
      t_look("R8 two sweeps miss", 0, a);
      check("R8 two sweeps explicit", 64'(m_hit(0, a)), 64'(0));

      // R9 refresh keeps the entry
      b = 48'h0000_BEEF_0002;
      t_learn(1, b);
      t_tick(); t_tick();
      t_learn(1, b);
      t_tick(); t_tick();
      t_look("R9 refreshed hit", 1, b);
      check("R9 explicit", 64'(m_hit(1, b)), 64'(1));

      // random traffic against the model (R3 R4 R5 R6 R8)
      for (int i = 0; i < 16; i++) begin
         pool[i] = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
         pool[i][40] = ($urandom % 6 == 0);
      end
      for (int n = 0; n < 400; n++) begin
         int r = $urandom % 12;
         int p = $urandom % NP;
         int s = $urandom % 16;
         if (r < 4)       t_learn(p, pool[s]);
         else if (r < 11) t_look("R3 random lookup", p, pool[s]);
         else             t_tick();
      end

      finish_run();
   end

endmodule